// File: doc/BRIEF.md
# Multichannel PWM generator with shadowed reload

This block drives a parameterised number of pulse-width-modulated outputs from one clock. For each channel, software writes three counts through a small 32-bit register port: the period, the high time (duty) and a start offset. The writes land in shadow registers and leave the running waveforms alone. When software sets the load bit in the control register, the block waits for the end of the running period and then copies every shadow set into its active set in one cycle. At that same moment every channel counter restarts, so all channels come out of the reload phase-aligned.

Each channel counts from zero up to period minus one and then wraps. The output is high while the count is below the duty value. After each synchronised restart, a channel first stays low for its offset count and then begins its first period. A period of zero turns the channel off. The control register also holds a core-reset bit, which freezes all counters and forces every output low until software clears it. A fixed set of read-only words identifies the block and reports how many channels it has.

Top module: `pwm_bank`

## Requirements
- R1: Read-only words: address 0x00 returns the version, which is major 1 in bits 31:16, minor in bits 15:8 and patch in bits 7:0, so 0x00010000 with the default parameters. Address 0x04 returns the identifier parameter (default 0). Address 0x0C returns 0x601A3471. Address 0x14 returns the channel count. Writes to any of these addresses leave them unchanged.
- R2: Address 0x08 is a 32-bit scratch word that reads back what was last written and resets to 0. An unmapped address reads 0.
- R3: The control word at 0x10 resets to 1. While its bit 0 (core reset) is 1, every output is low and every channel counter is held at its start.
- R4: Channel n has shadow words for period at 0x40+12n, duty at 0x44+12n and offset at 0x48+12n. Each reads back the value written and resets to 0. Writing them does not change any output until a load takes place.
- R5: Writing 1 to control bit 1 requests a load. The bit reads 1 while the request is pending and clears itself in the cycle the transfer happens. Writing 0 to it does not cancel a pending request.
- R6: A pending load takes effect at the clock edge that ends the period of the lowest-numbered channel whose active period is non-zero. If no channel is enabled, or the core is in reset, it takes effect at the next edge.
- R7: At a load, every channel copies its shadow words to its active set and restarts. The channel's output is low for its offset count of cycles and then starts a period with its counter at 0. Releasing core reset restarts the channels in the same way.
- R8: A running channel with period P and duty D repeats every P cycles and is high for the first D cycles of each repeat. If D is P or more, the output stays high.
- R9: A channel whose active period is 0 holds its output low, whatever its duty value.
- R10: A read request returns its data on the cycle after it is made, marked by a one-cycle valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register port and the PWM counters |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_waddr | input | AW | Byte address for a write |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_raddr | input | AW | Byte address for a read |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High for one cycle when read data is returned |
| pwm_out | output | NCH | One active-high PWM output per channel |

## Verification
The bench builds the block with three channels, 32-bit counts and an 8-bit address. With three channels the bench can make one channel the reference that sets the reload time, give a second channel an offset and a period different from the first, and switch the third off and later on. This shows that reloads are timed from the lowest enabled channel and that every channel restarts from the same edge. Periods of four to ten cycles make the reload wait and several complete repeats short enough to compare cycle by cycle. The 32-bit width still lets the bench check the duty-above-period case and the identifier words.

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int          NCH       = 3,
  parameter int          CW        = 32,
  parameter int          AW        = 8,
  parameter logic [31:0] CORE_ID   = 32'h0,
  parameter int          VER_MINOR = 0,
  parameter int          VER_PATCH = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_waddr,
  input  logic [31:0]    bus_wdata,
  input  logic           bus_re,
  input  logic [AW-1:0]  bus_raddr,
  output logic [31:0]    bus_rdata,
  output logic           bus_rvalid,
  output logic [NCH-1:0] pwm_out
);
  localparam logic [31:0] MAGIC   = 32'h601A3471;
  localparam logic [31:0] VERSION = {16'd1, 8'(VER_MINOR), 8'(VER_PATCH)};
  localparam int          CHB     = 64;
  localparam int          CHS     = 12;
  localparam logic [AW-1:0] A_VER = AW'(0);
  localparam logic [AW-1:0] A_ID  = AW'(4);
  localparam logic [AW-1:0] A_SCR = AW'(8);
  localparam logic [AW-1:0] A_MAG = AW'(12);
  localparam logic [AW-1:0] A_CFG = AW'(16);
  localparam logic [AW-1:0] A_NCH = AW'(20);

  logic [CW-1:0] shd_per [NCH];
  logic [CW-1:0] shd_duty[NCH];
  logic [CW-1:0] shd_off [NCH];
  logic [CW-1:0] act_per [NCH];
  logic [CW-1:0] act_duty[NCH];
  logic [CW-1:0] act_off [NCH];
  logic [CW-1:0] cnt     [NCH];
  logic [CW-1:0] dly     [NCH];
  logic [NCH-1:0] run;

  logic [31:0] scratch;
  logic        core_rst, load_pend;
  logic        ref_found, ref_end, xfer, cfg_wr;
  logic [31:0] rd_mux;

  assign cfg_wr = bus_we && (bus_waddr == A_CFG);
  assign xfer   = load_pend && (core_rst || !ref_found || ref_end);

  always_comb begin
    ref_found = 1'b0;
    ref_end   = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (act_per[i] != '0) begin
        ref_found = 1'b1;
        ref_end   = run[i] && (cnt[i] == act_per[i] - CW'(1));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scratch   <= '0;
      core_rst  <= 1'b1;
      load_pend <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        shd_per[i]  <= '0;
        shd_duty[i] <= '0;
        shd_off[i]  <= '0;
      end
    end else begin
      if (bus_we && bus_waddr == A_SCR) scratch <= bus_wdata;
      if (xfer) load_pend <= 1'b0;
      if (cfg_wr) begin
        core_rst <= bus_wdata[0];
        if (bus_wdata[1]) load_pend <= 1'b1;
      end
      for (int i = 0; i < NCH; i++) begin
        if (bus_we && bus_waddr == AW'(CHB + CHS * i))     shd_per[i]  <= bus_wdata[CW-1:0];
        if (bus_we && bus_waddr == AW'(CHB + CHS * i + 4)) shd_duty[i] <= bus_wdata[CW-1:0];
        if (bus_we && bus_waddr == AW'(CHB + CHS * i + 8)) shd_off[i]  <= bus_wdata[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (!rst_n) begin
        act_per[i]  <= '0;
        act_duty[i] <= '0;
        act_off[i]  <= '0;
        cnt[i]      <= '0;
        dly[i]      <= '0;
        run[i]      <= 1'b1;
      end else if (xfer) begin
        act_per[i]  <= shd_per[i];
        act_duty[i] <= shd_duty[i];
        act_off[i]  <= shd_off[i];
        cnt[i]      <= '0;
        dly[i]      <= '0;
        run[i]      <= (shd_off[i] == '0);
      end else if (core_rst) begin
        cnt[i] <= '0;
        dly[i] <= '0;
        run[i] <= (act_off[i] == '0);
      end else if (!run[i]) begin
        if (dly[i] == act_off[i] - CW'(1)) begin
          run[i] <= 1'b1;
          cnt[i] <= '0;
        end else begin
          dly[i] <= dly[i] + CW'(1);
        end
      end else if (act_per[i] != '0) begin
        cnt[i] <= (cnt[i] == act_per[i] - CW'(1)) ? '0 : cnt[i] + CW'(1);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++)
      pwm_out[i] = !core_rst && run[i] && (act_per[i] != '0) && (cnt[i] < act_duty[i]);
  end

  always_comb begin
    rd_mux = '0;
    if      (bus_raddr == A_VER) rd_mux = VERSION;
    else if (bus_raddr == A_ID)  rd_mux = CORE_ID;
    else if (bus_raddr == A_SCR) rd_mux = scratch;
    else if (bus_raddr == A_MAG) rd_mux = MAGIC;
    else if (bus_raddr == A_CFG) rd_mux = {30'd0, load_pend, core_rst};
    else if (bus_raddr == A_NCH) rd_mux = 32'(NCH);
    for (int i = 0; i < NCH; i++) begin
      if (bus_raddr == AW'(CHB + CHS * i))     rd_mux = 32'(shd_per[i]);
      if (bus_raddr == AW'(CHB + CHS * i + 4)) rd_mux = 32'(shd_duty[i]);
      if (bus_raddr == AW'(CHB + CHS * i + 8)) rd_mux = 32'(shd_off[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_re;
      bus_rdata  <= bus_re ? rd_mux : '0;
    end
  end

  AST_LOAD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pend && !core_rst && ref_found && !ref_end) |=> load_pend); // R6

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (run[g] && act_per[g] != '0) |-> (cnt[g] < act_per[g])); // R8
    AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(load_pend) |-> (cnt[g] == '0 && dly[g] == '0)); // R7
    AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst |=> (cnt[g] == '0)); // R3
  end
endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
  localparam int TCLK = 10;
  localparam int NCH  = 3;
  localparam logic [31:0] MAGIC = 32'h601A3471;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0] bus_waddr = '0, bus_raddr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid;
  logic [NCH-1:0] pwm_out;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  pwm_bank #(.NCH(NCH), .CW(32), .AW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_raddr(bus_raddr),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .pwm_out(pwm_out));

  always #(TCLK/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) check("R10 unrequested read data", 32'd1, 32'd0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    bus_re = 1'b1; bus_raddr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  function automatic logic [NCH-1:0] synced(int k, bit ch2_on);
    logic [NCH-1:0] v;
    v[0] = (k % 10) < 5;
    v[1] = (k < 2) ? 1'b0 : (((k - 2) % 5) < 2);
    v[2] = ch2_on ? ((k % 4) < 1) : 1'b0;
    return v;
  endfunction

  initial begin
    #(TCLK * 50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c1, cw, cx, pr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 outputs low after reset", 32'(pwm_out), 32'd0);
    rd(8'h10, 32'd1, "R3 control reset value");
    rd(8'h0C, MAGIC, "R1 magic");
    rd(8'h00, 32'h00010000, "R1 version");
    rd(8'h04, 32'd0, "R1 identifier");
    rd(8'h14, 32'(NCH), "R1 channel count");
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h14, 32'd9);
    rd(8'h0C, MAGIC, "R1 magic ignores write");
    rd(8'h14, 32'(NCH), "R1 count ignores write");
    rd(8'h08, 32'd0, "R2 scratch reset");
    wr(8'h08, 32'hA5C3_0F96);
    rd(8'h08, 32'hA5C3_0F96, "R2 scratch readback");
    rd(8'h3C, 32'd0, "R2 unmapped reads zero");
    rd(8'h40, 32'd0, "R4 shadow reset");

    wr(8'h10, 32'd0);
    wr(8'h40, 32'd10); wr(8'h44, 32'd3);
    wr(8'h4C, 32'd10); wr(8'h50, 32'd15);
    wr(8'h58, 32'd0);  wr(8'h5C, 32'd5);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R4 shadow writes leave outputs", 32'(pwm_out), 32'd0);
    end
    rd(8'h44, 32'd3, "R4 duty readback");
    rd(8'h50, 32'd15, "R4 duty readback ch1");
    rd(8'h10, 32'd0, "R5 control idle");

    wr(8'h10, 32'd2);
    c1 = cyc + 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check("R8 R9 first load waveform", 32'(pwm_out),
            32'({1'b0, 1'b1, ((k % 10) < 3)}));
    end
    rd(8'h10, 32'd0, "R5 load bit cleared");

    wr(8'h44, 32'd5);
    wr(8'h4C, 32'd5); wr(8'h50, 32'd2); wr(8'h54, 32'd2);
    wr(8'h10, 32'd2);
    cw = cyc;
    cx = cw + 1;
    while (((cx - c1) % 10) != 0) cx++;
    for (int c = cw; c < cx + 20; c++) begin
      if (c == cw) begin
        bus_re = 1'b1; bus_raddr = 8'h10;
        exp_q.push_back(32'd2); tag_q.push_back("R5 load pending");
      end else if (c == cw + 1) begin
        bus_re = 1'b0;
      end
      if (c < cx)
        check("R6 old waveform until period end", 32'(pwm_out),
              32'({1'b0, 1'b1, (((c - c1) % 10) < 3)}));
      else
        check("R7 synchronised restart", 32'(pwm_out), 32'(synced(c - cx, 1'b0)));
      @(negedge clk);
    end
    rd(8'h10, 32'd0, "R5 load bit cleared after wait");

    wr(8'h10, 32'd1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R3 core reset forces low", 32'(pwm_out), 32'd0);
    end
    wr(8'h58, 32'd4); wr(8'h5C, 32'd1);
    wr(8'h10, 32'd3);
    @(negedge clk);
    check("R6 load during core reset keeps low", 32'(pwm_out), 32'd0);
    rd(8'h10, 32'd1, "R6 load immediate in core reset");
    wr(8'h10, 32'd0);
    pr = cyc;
    for (int k = 0; k < 20; k++) begin
      check("R7 restart on core release", 32'(pwm_out), 32'(synced(k, 1'b1)));
      @(negedge clk);
    end
    if (pr < 0) check("R7 cycle count", 32'(pr), 32'd0);

    repeat (3) @(negedge clk);
    check("R10 every read answered", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule